// File: doc/BRIEF.md
# I2C Pin-Level Transaction Decoder

This block sits behind the two wires of an I2C bus. It turns clock and data line activity into byte-level commands for a target-side port. Both pins are first brought into the system clock domain through synchronizer chains. The core then looks for level changes:

- A data transition while the clock is high frames a transaction: falling data is a START, rising data is a STOP.
- Clock rising edges shift bits in or out.

The first byte after a START opens a transfer toward the target. Its upper seven bits are the target address and its lowest bit selects a read. Later bytes are handed on as write data. In a read, the block asks the target for each byte and shifts that byte out onto the bus.

The block has its own open-drain data output. It drives this output low in acknowledge slots and during read bits, and releases it on every clock falling edge. The level it reports for the bus is the wired-AND of that output and the master's synchronized data level.

Top module: `i2c_pin_decoder`

## Requirements
- R1: After reset, `sda_out` and `sda_line` are 1 and `cmd_valid` is 0.
- R2: A START is data falling while the clock is high. It restarts byte reception for a new address byte, forgets any captured address and releases `sda_out`. It issues no command.
- R3: A STOP is data rising while the clock is high. It issues a close command (kind 5) only when an address byte was captured since the last START. It then returns to idle, where clocks issue nothing.
- R4: Data changes while the clock is low issue no command and leave the bit being received unchanged.
- R5: Every clock falling edge releases `sda_out` (drives it to 1).
- R6: In write phase, bits are taken MSB first on clock rising edges. On the ninth rising edge the byte is emitted in `cmd_byte`: as an open command (kind 1) if it is the first byte after START, otherwise as a write command (kind 2). On that same edge `sda_out` is driven to 0 to acknowledge.
- R7: When the address byte has bit 0 set, the block enters read phase after the acknowledge. On the first rising edge of each read byte it issues a fetch command (kind 3) and samples `rd_byte` one system clock later. That byte then appears on `sda_out` MSB first, one bit per rising edge, over eight edges.
- R8: After eight read bits, the next rising edge samples the master's acknowledge. A 0 starts another read byte. A 1 issues a NACK command (kind 4), after which clock edges issue nothing and leave `sda_out` released until a START or STOP.
- R9: `sda_line` equals `sda_out` AND the synchronized master data level.
- R10: When both pins change in the same cycle, the data change is judged against the previous clock level before the clock edge is applied. For example, both lines falling together from idle is a START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_pin | input | 1 | Bus clock line, asynchronous |
| sda_pin | input | 1 | Master data line level, asynchronous |
| rd_byte | input | 8 | Target read byte, valid the cycle after a fetch command |
| sda_out | output | 1 | Block's own open-drain data level (1 = released) |
| sda_line | output | 1 | Effective data level, wired-AND of own and master |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 3 | 1 open, 2 write, 3 fetch, 4 NACK, 5 close |
| cmd_byte | output | 8 | Address byte (open) or data byte (write) |

## Verification
A wrong bit count or a wrong phase shows at the ports within one byte. The acknowledge low lands on the wrong clock pulse, the open or write strobe fires early or late, or the read bits come out shifted. A lost address flag shows only at the next STOP, as a missing or spurious close command. The bench therefore ends every scenario with a STOP. A stale halt state shows as missing commands after a restart. The simultaneous-edge and low-clock data-toggle cases make an ordering error appear as an absent open command.

// File: rtl/i2cd_pkg.sv
package i2cd_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WBIT = 3'd1,
    PH_WACK = 3'd2,
    PH_RBIT = 3'd3,
    PH_RACK = 3'd4,
    PH_HALT = 3'd5
  } phase_e;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_OPEN  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_FETCH = 3'd3,
    CMD_NACK  = 3'd4,
    CMD_CLOSE = 3'd5
  } cmd_e;
endpackage

// File: rtl/i2cd_sync.sv
module i2cd_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [WIDTH-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      prev_q <= '1;
    end else begin
      pipe_q[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign sync_o = pipe_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/i2cd_core.sv
module i2cd_core
  import i2cd_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_now,
  input  logic            scl_was,
  input  logic            sda_now,
  input  logic            sda_was,
  input  logic [BITS-1:0] rd_data,
  output logic            sda_o,
  output logic            cmd_valid,
  output cmd_e            cmd_kind,
  output logic [BITS-1:0] cmd_byte
);
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  phase_e          ph_q, ph_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [BITS-1:0] shr_q, shr_d, byte_d;
  logic            own_q, own_d, rd_q, rd_d, fetch_q, fetch_d, sda_q, sda_d;
  logic            cv_q, cv_d;
  cmd_e            kind_q, kind_d;
  logic [BITS-1:0] byte_q;
  logic            sda_chg, scl_rise, scl_fall, start_det, stop_det, rflag;

  assign sda_chg   = sda_now ^ sda_was;
  assign scl_rise  = scl_now & ~scl_was;
  assign scl_fall  = ~scl_now & scl_was;
  // data change judged against the clock level before this cycle's clock edge
  assign start_det = sda_chg & ~sda_now & scl_was;
  assign stop_det  = sda_chg & sda_now & scl_was;

  always_comb begin
    ph_d = ph_q; cnt_d = cnt_q; shr_d = shr_q; own_d = own_q; rd_d = rd_q;
    fetch_d = 1'b0; sda_d = sda_q; cv_d = 1'b0; kind_d = CMD_NONE; byte_d = shr_q;
    rflag = 1'b0;
    if (fetch_q) begin
      sda_d = rd_data[BITS-1];
      shr_d = {rd_data[BITS-2:0], 1'b0};
    end
    if (start_det) begin
      ph_d = PH_WBIT; cnt_d = '0; own_d = 1'b0; sda_d = 1'b1;
    end else if (stop_det) begin
      if (own_q) begin
        cv_d = 1'b1; kind_d = CMD_CLOSE;
      end
      own_d = 1'b0; ph_d = PH_IDLE; sda_d = 1'b1;
    end
    if (scl_rise) begin
      unique case (ph_d)
        PH_WBIT: begin
          shr_d = {shr_d[BITS-2:0], sda_now};
          sda_d = 1'b1;
          if (cnt_d == LAST) begin ph_d = PH_WACK; cnt_d = '0; end
          else cnt_d = cnt_d + 1'b1;
        end
        PH_WACK: begin
          cv_d   = 1'b1;
          byte_d = shr_d;
          rflag  = own_d ? rd_q : shr_d[0];
          if (!own_d) begin
            kind_d = CMD_OPEN; own_d = 1'b1; rd_d = shr_d[0];
          end else begin
            kind_d = CMD_WRITE;
          end
          sda_d = 1'b0;
          ph_d  = rflag ? PH_RBIT : PH_WBIT;
          cnt_d = '0;
        end
        PH_RBIT: begin
          if (cnt_d == '0) begin
            cv_d = 1'b1; kind_d = CMD_FETCH; fetch_d = 1'b1; sda_d = 1'b1;
          end else begin
            sda_d = shr_d[BITS-1];
            shr_d = {shr_d[BITS-2:0], 1'b0};
          end
          if (cnt_d == LAST) begin ph_d = PH_RACK; cnt_d = '0; end
          else cnt_d = cnt_d + 1'b1;
        end
        PH_RACK: begin
          sda_d = 1'b1;
          cnt_d = '0;
          if (sda_now) begin
            cv_d = 1'b1; kind_d = CMD_NACK; ph_d = PH_HALT;
          end else begin
            ph_d = PH_RBIT;
          end
        end
        default: sda_d = 1'b1;
      endcase
    end
    if (scl_fall) sda_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; cnt_q <= '0; shr_q <= '0; own_q <= 1'b0; rd_q <= 1'b0;
      fetch_q <= 1'b0; sda_q <= 1'b1; cv_q <= 1'b0; kind_q <= CMD_NONE; byte_q <= '0;
    end else begin
      ph_q <= ph_d; cnt_q <= cnt_d; shr_q <= shr_d; own_q <= own_d; rd_q <= rd_d;
      fetch_q <= fetch_d; sda_q <= sda_d; cv_q <= cv_d; kind_q <= kind_d;
      if (cv_d) byte_q <= byte_d;
    end
  end

  assign sda_o     = sda_q;
  assign cmd_valid = cv_q;
  assign cmd_kind  = kind_q;
  assign cmd_byte  = byte_q;

  a_r5_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> sda_q);
  a_r2_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (sda_q && !cv_q));
  a_r3_close_needs_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_q && kind_q == CMD_CLOSE) |-> $past(own_q));
  a_r6_ack_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_q && (kind_q == CMD_OPEN || kind_q == CMD_WRITE)) |-> !sda_q);
  a_r8_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HALT && !sda_chg) |=> (!cv_q && sda_q));
endmodule

// File: rtl/i2c_pin_decoder.sv
module i2c_pin_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_pin,
  input  logic                 sda_pin,
  input  logic [BYTE_BITS-1:0] rd_byte,
  output logic                 sda_out,
  output logic                 sda_line,
  output logic                 cmd_valid,
  output logic [2:0]           cmd_kind,
  output logic [BYTE_BITS-1:0] cmd_byte
);
  import i2cd_pkg::*;

  logic [1:0] pins_s, pins_p;
  cmd_e       kind_w;

  i2cd_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    ({scl_pin, sda_pin}),
    .sync_o (pins_s),
    .prev_o (pins_p)
  );

  i2cd_core #(.BITS(BYTE_BITS)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_now   (pins_s[1]),
    .scl_was   (pins_p[1]),
    .sda_now   (pins_s[0]),
    .sda_was   (pins_p[0]),
    .rd_data   (rd_byte),
    .sda_o     (sda_out),
    .cmd_valid (cmd_valid),
    .cmd_kind  (kind_w),
    .cmd_byte  (cmd_byte)
  );

  assign cmd_kind = kind_w;
  assign sda_line = sda_out & pins_s[0];

  a_r9_wired_and: assert property (@(posedge clk) disable iff (!rst_n)
    (!pins_s[0]) |-> !sda_line);
endmodule

// File: tb/i2c_pin_decoder_tb.sv
module i2c_pin_decoder_tb;
  logic       clk, rst_n, scl, sda;
  logic [7:0] rd_val;
  logic       sda_out, sda_line, cmd_valid;
  logic [2:0] cmd_kind;
  logic [7:0] cmd_byte;

  int n_tests, n_fail, n_cmd;
  logic [2:0] lk [32];
  logic [7:0] lb [32];
  bit done;

  i2c_pin_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .scl_pin(scl), .sda_pin(sda), .rd_byte(rd_val),
    .sda_out(sda_out), .sda_line(sda_line), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_byte(cmd_byte)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      if (n_cmd < 32) begin
        lk[n_cmd] = cmd_kind;
        lb[n_cmd] = cmd_byte;
      end
      n_cmd = n_cmd + 1;
    end
  end

  localparam logic [15:0] VEC [6] = '{16'hA0_5A, 16'h3C_00, 16'hFE_FF,
                                      16'h02_81, 16'h7E_13, 16'h54_C6};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set(input logic c, input logic d);
    @(negedge clk);
    scl = c;
    sda = d;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_start();
    set(1'b0, sda); set(1'b0, 1'b1); set(1'b1, 1'b1); set(1'b1, 1'b0); set(1'b0, 1'b0);
  endtask

  task automatic bus_stop();
    set(1'b0, sda); set(1'b0, 1'b0); set(1'b1, 1'b0); set(1'b1, 1'b1);
  endtask

  task automatic send_byte(input logic [7:0] b, input string req);
    for (int i = 7; i >= 0; i--) begin
      set(1'b0, b[i]); set(1'b1, b[i]); set(1'b0, b[i]);
    end
    set(1'b0, 1'b1);
    set(1'b1, 1'b1);
    chk(sda_line == 1'b0, req, sda_line, 0);
    set(1'b0, 1'b1);
    chk(sda_line == 1'b1, "R5 release after ack", sda_line, 1);
  endtask

  task automatic read_byte(input logic ack, output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      set(1'b1, 1'b1);
      v = {v[6:0], sda_line};
      set(1'b0, 1'b1);
    end
    set(1'b0, ack); set(1'b1, ack); set(1'b0, ack); set(1'b0, 1'b1);
  endtask

  initial begin
    logic [7:0] got;
    n_tests = 0; n_fail = 0; n_cmd = 0; done = 0;
    scl = 1'b1; sda = 1'b1; rd_val = 8'h00; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(sda_out == 1'b1 && sda_line == 1'b1, "R1 lines high", {sda_out, sda_line}, 3);
    chk(n_cmd == 0, "R1 no command", n_cmd, 0);

    // R6 / R3: write transactions from the vector table
    foreach (VEC[k]) begin
      n_cmd = 0;
      bus_start();
      send_byte(VEC[k][15:8], "R6 address ack low");
      send_byte(VEC[k][7:0], "R6 data ack low");
      bus_stop();
      chk(n_cmd == 3, "R6 command count", n_cmd, 3);
      chk(lk[0] == 3'd1 && lb[0] == VEC[k][15:8], "R6 open byte", {lk[0], lb[0]}, {3'd1, VEC[k][15:8]});
      chk(lk[1] == 3'd2 && lb[1] == VEC[k][7:0], "R6 write byte", {lk[1], lb[1]}, {3'd2, VEC[k][7:0]});
      chk(lk[2] == 3'd5, "R3 close after address", lk[2], 5);
    end

    // R3: STOP with no address captured issues nothing
    n_cmd = 0;
    bus_start();
    bus_stop();
    bus_start();
    set(1'b0, 1'b1); set(1'b1, 1'b1); set(1'b0, 1'b1);
    set(1'b0, 1'b0); set(1'b1, 1'b0); set(1'b0, 1'b0);
    bus_stop();
    chk(n_cmd == 0, "R3 no close without address", n_cmd, 0);
    set(1'b0, 1'b1); set(1'b1, 1'b1); set(1'b0, 1'b1); set(1'b1, 1'b1);
    chk(n_cmd == 0, "R3 idle ignores clocks", n_cmd, 0);

    // R2: repeated START forgets previous address; new first byte opens again
    n_cmd = 0;
    bus_start();
    send_byte(8'h10, "R6 ack");
    bus_start();
    chk(sda_out == 1'b1, "R2 start releases", sda_out, 1);
    send_byte(8'h20, "R6 ack");
    bus_stop();
    chk(n_cmd == 3 && lk[1] == 3'd1 && lb[1] == 8'h20, "R2 repeated start reopens", {lk[1], lb[1]}, {3'd1, 8'h20});

    // R4: data toggles while clock low are ignored
    n_cmd = 0;
    bus_start();
    set(1'b0, 1'b1); set(1'b0, 1'b0); set(1'b0, 1'b1); set(1'b0, 1'b0);
    chk(n_cmd == 0, "R4 no command on low-clock toggles", n_cmd, 0);
    send_byte(8'h22, "R6 ack");
    bus_stop();
    chk(n_cmd == 2 && lk[0] == 3'd1 && lb[0] == 8'h22, "R4 byte intact", {lk[0], lb[0]}, {3'd1, 8'h22});

    // R7 / R8: read transaction, ack then NACK
    n_cmd = 0;
    bus_start();
    send_byte(8'hA3, "R6 read address ack");
    rd_val = 8'hA5;
    read_byte(1'b0, got);
    chk(got == 8'hA5, "R7 first read byte", got, 8'hA5);
    rd_val = 8'h3C;
    read_byte(1'b1, got);
    chk(got == 8'h3C, "R7 second read byte", got, 8'h3C);
    chk(n_cmd == 4, "R8 command count before stop", n_cmd, 4);
    chk(lk[0] == 3'd1 && lk[1] == 3'd3 && lk[2] == 3'd3, "R7 fetch per byte", {lk[1], lk[2]}, {3'd3, 3'd3});
    chk(lk[3] == 3'd4, "R8 NACK command", lk[3], 4);
    set(1'b1, 1'b1); set(1'b0, 1'b1); set(1'b1, 1'b1); set(1'b0, 1'b1);
    chk(n_cmd == 4 && sda_line == 1'b1, "R8 halt ignores clocks", n_cmd, 4);
    bus_stop();
    chk(n_cmd == 5 && lk[4] == 3'd5, "R3 close after read", lk[4], 5);

    // R9: wired-AND with master level
    set(1'b0, 1'b1);
    set(1'b0, 1'b0);
    chk(sda_out == 1'b1 && sda_line == 1'b0, "R9 master low pulls line", {sda_out, sda_line}, 2);
    set(1'b0, 1'b1);
    set(1'b1, 1'b1);

    // R10: both lines fall together from idle -> START
    n_cmd = 0;
    set(1'b0, 1'b0);
    send_byte(8'h40, "R6 ack after joint edge");
    bus_stop();
    chk(n_cmd == 2 && lk[0] == 3'd1 && lb[0] == 8'h40, "R10 joint edge is start", {lk[0], lb[0]}, {3'd1, 8'h40});

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule